// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Control

This block is a watchdog that raises a one-cycle reset request when software stops clearing it in time. Its whole configuration sits in one 32-bit control word on a small register bus (address, write strobe, write data, combinational read data). A control write takes effect only when a two-write key handshake precedes it. A lock bit freezes the configuration until the next reset.

The timer advances on count-enable pulses from one of two slow tick inputs, which stand in for an on-chip RC clock and a 32 kHz crystal clock. A tick-gate bit stops counting altogether. In basic mode the timer runs one timeout interval. In window mode an early-clear ban interval comes before that timeout interval. A clear that arrives inside the ban interval is treated as a fault: it raises a reset request and restarts the counter.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset the control word reads 0x00010080 and `rst_req` is low. Field layout: key [31:24], ban select [22:18], source select [17], tick gate [16], timeout select [12:8], calibration-done flag [7], lock [3], window mode [2], spare flag [1], enable [0]. All other bits read as zero.
- R2: A write to the control address is applied only when it is the second of two consecutive control writes, the first carrying key 0x55 and the second carrying key 0xAA. Any other write sequence leaves the word unchanged.
- R3: The key field [31:24] always reads back as zero.
- R4: In basic mode (bit 2 = 0) a `rst_req` pulse of one cycle is raised 2^(sel+1) ticks after the counter last restarted, where sel is bits [12:8]. The counter then restarts from zero.
- R5: In window mode (bit 2 = 1) the timeout comes 2^(ban+1) + 2^(sel+1) ticks after a restart, where ban is bits [22:18].
- R6: In window mode, a clear that arrives while the tick count is below 2^(ban+1) raises `rst_req` in the next cycle and restarts the counter. A clear at exactly 2^(ban+1) ticks or later only restarts the counter.
- R7: A clear request while enabled restarts the count from zero, which moves the next timeout to 2^(sel+1) ticks (basic mode) after the clear edge.
- R8: Once the lock bit (bit 3) is committed, all further control writes are ignored. Only reset clears the lock.
- R9: A committed write leaves the window-mode bit unchanged while the enable bit (bit 0) is already 1.
- R10: Bit 17 selects the tick source: 0 for `tick_rc`, 1 for `tick_xtal`. When bit 16 is 0, no ticks are counted.
- R11: While enable is 0 the counter is held at zero and clear requests never raise `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tick_rc | input | 1 | Count enable from the RC-clock source |
| tick_xtal | input | 1 | Count enable from the crystal-clock source |
| clear_req | input | 1 | Watchdog clear strobe |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench hits the window boundary exactly. It clears at ban-count minus one, which must fault, and at the ban count itself, which must not. An off-by-one comparator would either miss the fault or fire it on a legal clear. Lone 0xAA writes and a 0x55 followed by a wrong key must leave the word untouched, so a design that arms on any key fails. It also tries to flip the mode bit while enabled and to write through the lock; a design that ignores either rule shows a changed readback. Timeout edges are predicted to the exact cycle in basic mode, in window mode, after a mid-period clear and after a source switch, so a counter that restarts at one instead of zero shifts every pulse.

// File: rtl/kww_pkg.sv
// Shared control-word layout and constants for the keyed window watchdog.
// Assumes a 32-bit control word; field positions are fixed by the layout below.
package kww_pkg;

    typedef struct packed {
        logic [7:0] key;        // handshake key, never stored
        logic       rsv23;
        logic [4:0] ban_sel;    // ban interval = 2^(ban_sel+1) ticks
        logic       src_sel;    // 0: RC tick, 1: crystal tick
        logic       tick_gate;  // 1: ticks counted
        logic [2:0] rsv15;
        logic [4:0] tmo_sel;    // timeout = 2^(tmo_sel+1) ticks
        logic       cal_done;
        logic [2:0] rsv6;
        logic       lock;
        logic       win_mode;
        logic       spare;
        logic       enable;
    } ctrl_t;

    localparam logic [7:0]  KEY_ARM    = 8'h55;
    localparam logic [7:0]  KEY_FIRE   = 8'hAA;
    localparam logic [31:0] CTRL_RESET = 32'h0001_0080;
    localparam logic [31:0] WR_MASK    = 32'h007F_1F8F;

endpackage

// File: rtl/kww_ctrl_reg.sv
// Control register with two-write key handshake, lock and mode freeze.
// Assumes one write per strobe cycle; reads are combinational.
module kww_ctrl_reg
    import kww_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output ctrl_t             cfg
);

    logic  wr_hit;
    logic  armed_q;
    ctrl_t cfg_q;
    ctrl_t cfg_next;

    assign wr_hit = bus_we && (bus_addr == REG_ADDR);

    // Build the candidate word: drop key and reserved bits, freeze mode when running.
    always_comb begin
        cfg_next = ctrl_t'(bus_wdata & WR_MASK);
        if (cfg_q.enable) begin
            cfg_next.win_mode = cfg_q.win_mode;
        end
    end

    // Key sequencer and register update; lock blocks every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= ctrl_t'(CTRL_RESET);
            armed_q <= 1'b0;
        end else if (wr_hit && !cfg_q.lock) begin
            if (armed_q) begin
                armed_q <= 1'b0;
                if (bus_wdata[31:24] == KEY_FIRE) begin
                    cfg_q <= cfg_next;
                end
            end else begin
                armed_q <= (bus_wdata[31:24] == KEY_ARM);
            end
        end
    end

    // Read mux: stored word at the register address, zero elsewhere.
    always_comb begin
        bus_rdata = (bus_addr == REG_ADDR) ? 32'(cfg_q) : 32'h0;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/kww_tick_sel.sv
// Picks the tick source and applies the tick gate and enable.
// Assumes tick inputs are already synchronous single-cycle enables.
module kww_tick_sel (
    input  logic tick_rc,
    input  logic tick_xtal,
    input  logic src_sel,
    input  logic tick_gate,
    input  logic enable,
    output logic tick
);

    // Source mux followed by the gate.
    always_comb begin
        tick = (src_sel ? tick_xtal : tick_rc) && tick_gate && enable;
    end

endmodule

// File: rtl/kww_period_calc.sv
// Turns the select fields into interval lengths in ticks.
// Assumes CNT_W is wide enough for 2^33.
module kww_period_calc #(
    parameter int CNT_W = 34
) (
    input  logic [4:0]       ban_sel,
    input  logic [4:0]       tmo_sel,
    input  logic             win_mode,
    output logic [CNT_W-1:0] ban_len,
    output logic [CNT_W-1:0] total_len
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] tmo_len;

    // Power-of-two lengths; the ban interval exists only in window mode.
    always_comb begin
        tmo_len   = ONE << (6'(tmo_sel) + 6'd1);
        ban_len   = win_mode ? (ONE << (6'(ban_sel) + 6'd1)) : '0;
        total_len = ban_len + tmo_len;
    end

endmodule

// File: rtl/kww_counter.sv
// Tick counter with clear, ban-window fault and timeout pulse.
// Assumes total_len >= 2; counter held at zero while disabled.
module kww_counter #(
    parameter int CNT_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             clear_req,
    input  logic [CNT_W-1:0] ban_len,
    input  logic [CNT_W-1:0] total_len,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             in_ban;
    logic             at_end;

    // Window position and end-of-period detection.
    always_comb begin
        in_ban = cnt_q < ban_len;
        at_end = (cnt_q + ONE) >= total_len;
    end

    // Count, restart on clear, pulse on timeout or banned clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!enable) begin
                cnt_q <= '0;
            end else if (clear_req) begin
                cnt_q   <= '0;
                pulse_q <= in_ban;
            end else if (tick) begin
                if (at_end) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end
        end
    end

    assign cnt     = cnt_q;
    assign rst_req = pulse_q;

endmodule

// File: rtl/keyed_window_watchdog.sv
// Top of the keyed window watchdog: control register, tick select,
// period calculation and counter. Assumes a single control register.
module keyed_window_watchdog
    import kww_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int                CNT_W    = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_rc,
    input  logic              tick_xtal,
    input  logic              clear_req,
    output logic              rst_req
);

    ctrl_t            cfg;
    logic             tick;
    logic [CNT_W-1:0] ban_len;
    logic [CNT_W-1:0] total_len;
    logic [CNT_W-1:0] cnt;

    kww_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg)
    );

    kww_tick_sel u_tick (
        .tick_rc(tick_rc), .tick_xtal(tick_xtal), .src_sel(cfg.src_sel),
        .tick_gate(cfg.tick_gate), .enable(cfg.enable), .tick(tick)
    );

    kww_period_calc #(.CNT_W(CNT_W)) u_calc (
        .ban_sel(cfg.ban_sel), .tmo_sel(cfg.tmo_sel), .win_mode(cfg.win_mode),
        .ban_len(ban_len), .total_len(total_len)
    );

    kww_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(cfg.enable), .tick(tick),
        .clear_req(clear_req), .ban_len(ban_len), .total_len(total_len),
        .cnt(cnt), .rst_req(rst_req)
    );

endmodule

// File: rtl/kww_checker.sv
// Temporal checks for the keyed window watchdog, bound to the top.
module kww_checker #(
    parameter int CNT_W = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_req,
    input logic             rst_req,
    input logic             en_q,
    input logic             mode_q,
    input logic             lock_q,
    input logic [31:0]      cfg_word,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] ban_len
);

    assert_lock_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_locked_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(cfg_word));

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(mode_q));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !rst_req);

    assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && clear_req) |=> (cnt_q == '0));

    assert_ban_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && clear_req && (cnt_q < ban_len)) |=> rst_req);

endmodule

bind keyed_window_watchdog kww_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .rst_req(rst_req),
    .en_q(cfg.enable), .mode_q(cfg.win_mode), .lock_q(cfg.lock),
    .cfg_word(32'(cfg)), .cnt_q(cnt), .ban_len(ban_len)
);

// File: tb/keyed_window_watchdog_test.sv
// Scoreboard bench: tasks queue expected reset-pulse cycles, a monitor pops them.
module keyed_window_watchdog_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASIC8 = 32'h0001_0201;
    localparam logic [31:0] WIN12  = 32'h0005_0205;
    localparam logic [31:0] DIS    = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_rc = 1'b1;
    logic        tick_xtal = 1'b0;
    logic        clear_req = 1'b0;
    logic        rst_req;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    bit finished = 1'b0;

    keyed_window_watchdog uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_rc(tick_rc),
        .tick_xtal(tick_xtal), .clear_req(clear_req), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Monitor: every rst_req pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check(1'b0, "R4/R5/R6 missed pulse", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (rst_req) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    check(1'b1, "pulse", cyc, cyc);
                    void'(exp_q.pop_front());
                end else begin
                    check(1'b0, "R4/R6/R11 unexpected pulse", cyc,
                          exp_q.size() > 0 ? exp_q[0] : -1);
                end
            end
        end
    end

    task automatic bus_write(input logic [31:0] d, output int c);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = '0; bus_wdata = d;
        @(posedge clk); #1 c = cyc;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic keyed_write(input logic [31:0] d, output int c);
        int c0;
        bus_write({8'h55, d[23:0]}, c0);
        bus_write({8'hAA, d[23:0]}, c);
    endtask

    task automatic read_reg(output logic [31:0] v);
        @(negedge clk);
        bus_addr = '0;
        #1 v = bus_rdata;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Clear sampled at edge number c.
    task automatic clear_at(input int c);
        do @(negedge clk); while (cyc < c - 1);
        clear_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear_req = 1'b0;
    endtask

    task automatic quiet_for(input int n, input string req);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        check(!seen, req, 32'(seen), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p;
        int b;
        int q;
        int dummy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value
        read_reg(v);
        check(v == 32'h0001_0080, "R1 reset word", v, 32'h0001_0080);
        check(rst_req == 1'b0, "R1 rst_req low", 32'(rst_req), 0);

        // R2: lone fire key, and arm followed by wrong key
        bus_write({8'hAA, BASIC8[23:0]}, dummy);
        read_reg(v);
        check(v == 32'h0001_0080, "R2 lone 0xAA ignored", v, 32'h0001_0080);
        bus_write({8'h55, BASIC8[23:0]}, dummy);
        bus_write({8'h12, BASIC8[23:0]}, dummy);
        read_reg(v);
        check(v == 32'h0001_0080, "R2 wrong second key ignored", v, 32'h0001_0080);

        // R2/R3/R4: valid commit in basic mode, 8-tick timeout
        keyed_write(BASIC8, p);
        exp_q.push_back(p + 8);
        exp_q.push_back(p + 16);
        read_reg(v);
        check(v == BASIC8, "R2 keyed write applied", v, BASIC8);
        check(v[31:24] == 8'h00, "R3 key reads zero", 32'(v[31:24]), 0);

        // R9: mode change ignored while enabled
        keyed_write(32'h0001_0205, dummy);
        read_reg(v);
        check(v[2] == 1'b0, "R9 mode frozen while enabled", v, BASIC8);
        wait_until(p + 17);
        keyed_write(DIS, dummy);
        wait_until(p + 30);

        // R7: clear moves the timeout
        keyed_write(BASIC8, p);
        clear_at(p + 5);
        exp_q.push_back(p + 13);
        wait_until(p + 14);
        keyed_write(DIS, dummy);
        check(exp_q.size() == 0, "R7 restart after clear", exp_q.size(), 0);

        // R11: clears while disabled do nothing
        clear_at(cyc + 3);
        clear_at(cyc + 3);
        quiet_for(20, "R11 disabled stays quiet");

        // R5: window mode, 4 + 8 ticks
        keyed_write(WIN12, p);
        read_reg(v);
        check(v == WIN12, "R5 window config applied", v, WIN12);
        exp_q.push_back(p + 12);
        wait_until(p + 12);
        b = p + 12;
        // R6: clear at count 3 is banned
        exp_q.push_back(b + 4);
        clear_at(b + 4);
        b = b + 4;
        // R6: clear at count 4 is legal
        clear_at(b + 5);
        b = b + 5;
        exp_q.push_back(b + 12);
        wait_until(b + 13);
        keyed_write(DIS, dummy);
        check(exp_q.size() == 0, "R6 ban boundary", exp_q.size(), 0);
        wait_until(cyc + 15);

        // R10: tick gate off
        keyed_write(32'h0000_0201, dummy);
        quiet_for(20, "R10 tick gate off");
        keyed_write(DIS, dummy);
        // R10: crystal source selected, crystal idle
        keyed_write(32'h0003_0201, dummy);
        quiet_for(12, "R10 RC ticks ignored on crystal source");
        @(negedge clk);
        tick_xtal = 1'b1;
        q = cyc + 1;
        exp_q.push_back(q + 7);
        wait_until(q + 8);
        keyed_write(DIS, dummy);
        tick_xtal = 1'b0;
        check(exp_q.size() == 0, "R10 crystal ticks counted", exp_q.size(), 0);

        // R8: lock, then reset unlocks
        keyed_write(BASIC8 | 32'h8, p);
        exp_q.push_back(p + 8);
        exp_q.push_back(p + 16);
        keyed_write(DIS, dummy);
        read_reg(v);
        check(v == (BASIC8 | 32'h8), "R8 locked write ignored", v, BASIC8 | 32'h8);
        wait_until(p + 17);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_reg(v);
        check(v == 32'h0001_0080, "R8 reset clears lock", v, 32'h0001_0080);
        keyed_write(32'h0001_0200, dummy);
        read_reg(v);
        check(v == 32'h0001_0200, "R8 writable after reset", v, 32'h0001_0200);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule